// File: doc/BRIEF.md
# Single-Bus Eight-Bit Datapath

This block is the datapath of a very small stored-program computer. A program counter, a memory address register, a 16-word by 8-bit RAM, an instruction register, an accumulator, a second operand register, a two's-complement adder-subtracter and an output port all exchange data over one shared 8-bit bus. Each clock cycle, at most one source places a value on that bus and any number of registers capture it on the next rising edge.

The block does no sequencing of its own. An external 12-bit control word, supplied each cycle by a sequencer or a test harness, enables one bus source and selects which registers load. Most of the load strobes in that word are active low. Before a run, the RAM is filled through a separate write port. The upper nibble of the instruction register is exported as the opcode so that an outside sequencer can choose its next control words.

Top module: `tiny_bus_datapath`

## Requirements
- R1: While `clr` is high at a rising edge, every register clears to zero: program counter, address register, instruction register, accumulator, operand register and output port. After that edge `opcode`, `acc_q` and `out_q` read 0, and the program counter puts 0x00 on the bus.
- R2: When no bus source is enabled, `bus_q` reads 0x00. At most one source is enabled in any cycle.
- R3: With control bit 10 high, the program counter drives the bus, zero-extended. With control bit 9 low, the address register loads the low 4 bits of the bus at the edge.
- R4: With control bit 11 high, the program counter increments by one at the edge.
- R5: With control bit 8 low, the RAM word selected by the address register drives the bus. When `prog_we` is high at an edge, `prog_data` is written to `prog_addr`.
- R6: With control bit 7 low, the instruction register loads the bus, and `opcode` then shows its upper 4 bits. With control bit 6 low, the register drives its lower 4 bits onto the bus, and the upper 4 bus bits read zero.
- R7: With control bit 5 low, the accumulator loads the bus. With control bit 4 high, the accumulator drives the bus.
- R8: With control bit 2 high, the adder-subtracter drives the bus. It drives A+B when bit 3 is low and A-B when bit 3 is high, both modulo 256.
- R9: With control bit 1 low, the operand register loads the bus. With control bit 0 low, the output port loads the bus.
- R10: A register whose load strobe is inactive keeps its value. The all-inactive word 0x3E3 leaves the accumulator, output port and opcode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear of all registers, active high |
| ctrl | input | 12 | Control word, one strobe per bit, bit 11 first |
| prog_we | input | 1 | RAM preload write enable |
| prog_addr | input | 4 | RAM preload address |
| prog_data | input | 8 | RAM preload data |
| opcode | output | 4 | Upper nibble of the instruction register |
| acc_q | output | 8 | Accumulator contents |
| out_q | output | 8 | Output port contents |
| bus_q | output | 8 | Current value on the shared bus |

## Verification
The bench uses the default parameters: an 8-bit word, 4-bit addresses and the shared-adder form of the adder-subtracter. With these values the whole 16-word memory can be reached, including address 0xF, which the bench selects by routing the accumulator's low nibble into the address register. An add that carries past bit 7 and a subtract that borrows are both driven, so the modulo-256 wrap is exercised in each direction. The bench runs a load, an add, a subtract and an output instruction through hand-driven fetch and execute words, then applies a mid-run clear.

// File: rtl/busdp_pkg.sv
package busdp_pkg;
   localparam int CW = 12;

   // External control word; field order is fixed by the bit positions a sequencer drives.
   typedef struct packed {
      logic pc_inc;     // bit 11
      logic pc_oe;      // bit 10
      logic mar_ld_n;   // bit 9
      logic ram_oe_n;   // bit 8
      logic ir_ld_n;    // bit 7
      logic ir_oe_n;    // bit 6
      logic acc_ld_n;   // bit 5
      logic acc_oe;     // bit 4
      logic alu_sub;    // bit 3
      logic alu_oe;     // bit 2
      logic b_ld_n;     // bit 1
      logic out_ld_n;   // bit 0
   } ctrl_t;
endpackage

// File: rtl/dp_reg.sv
module dp_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         ld_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (clr)        q <= '0;
      else if (!ld_n) q <= d;
   end
endmodule

// File: rtl/dp_pc.sv
module dp_pc #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (clr)      q <= '0;
      else if (inc) q <= q + W'(1);
   end
endmodule

// File: rtl/dp_ram.sv
module dp_ram #(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/dp_addsub.sv
module dp_addsub #(
   parameter int W            = 8,
   parameter bit SPLIT_ADDSUB = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum
);
   generate
      if (SPLIT_ADDSUB) begin : g_split
         // two carry chains, result chosen afterwards
         logic [W-1:0] s_add, s_sub;
         assign s_add = a + b;
         assign s_sub = a - b;
         assign sum   = sub ? s_sub : s_add;
      end else begin : g_shared
         // one carry chain: invert B and inject the carry
         logic [W-1:0] b_x;
         assign b_x = b ^ {W{sub}};
         assign sum = a + b_x + W'(sub);
      end
   endgenerate
endmodule

// File: rtl/tiny_bus_datapath.sv
module tiny_bus_datapath
   import busdp_pkg::*;
#(
   parameter int DW           = 8,
   parameter int AW           = 4,
   parameter bit SPLIT_ADDSUB = 1'b0
) (
   input  logic          clk,
   input  logic          clr,
   input  logic [CW-1:0] ctrl,
   input  logic          prog_we,
   input  logic [AW-1:0] prog_addr,
   input  logic [DW-1:0] prog_data,
   output logic [DW-AW-1:0] opcode,
   output logic [DW-1:0] acc_q,
   output logic [DW-1:0] out_q,
   output logic [DW-1:0] bus_q
);
   localparam int OPW = DW - AW;

   generate
      if (AW < 1) begin : g_chk_aw
         $error("tiny_bus_datapath: AW must be at least 1");
      end
      if (DW <= AW) begin : g_chk_dw
         $error("tiny_bus_datapath: DW must exceed AW");
      end
   endgenerate

   ctrl_t cw;
   assign cw = ctrl_t'(ctrl);

   logic [AW-1:0] pc_q, mar_q;
   logic [DW-1:0] ir_q, b_q, ram_rd, alu_s;
   logic [DW-1:0] bus;

   dp_pc #(.W(AW)) u_pc (
      .clk(clk), .clr(clr), .inc(cw.pc_inc), .q(pc_q)
   );

   dp_reg #(.W(AW)) u_mar (
      .clk(clk), .clr(clr), .ld_n(cw.mar_ld_n), .d(bus[AW-1:0]), .q(mar_q)
   );

   dp_ram #(.DW(DW), .AW(AW)) u_ram (
      .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
      .raddr(mar_q), .rdata(ram_rd)
   );

   dp_reg #(.W(DW)) u_ir (
      .clk(clk), .clr(clr), .ld_n(cw.ir_ld_n), .d(bus), .q(ir_q)
   );

   dp_reg #(.W(DW)) u_acc (
      .clk(clk), .clr(clr), .ld_n(cw.acc_ld_n), .d(bus), .q(acc_q)
   );

   dp_reg #(.W(DW)) u_b (
      .clk(clk), .clr(clr), .ld_n(cw.b_ld_n), .d(bus), .q(b_q)
   );

   dp_reg #(.W(DW)) u_out (
      .clk(clk), .clr(clr), .ld_n(cw.out_ld_n), .d(bus), .q(out_q)
   );

   dp_addsub #(.W(DW), .SPLIT_ADDSUB(SPLIT_ADDSUB)) u_alu (
      .a(acc_q), .b(b_q), .sub(cw.alu_sub), .sum(alu_s)
   );

   // AND-OR merge: each enabled source contributes, idle bus is zero
   always_comb begin
      bus = '0;
      if (cw.pc_oe)     bus = bus | {{OPW{1'b0}}, pc_q};
      if (!cw.ram_oe_n) bus = bus | ram_rd;
      if (!cw.ir_oe_n)  bus = bus | {{OPW{1'b0}}, ir_q[AW-1:0]};
      if (cw.acc_oe)    bus = bus | acc_q;
      if (cw.alu_oe)    bus = bus | alu_s;
   end

   assign bus_q  = bus;
   assign opcode = ir_q[DW-1:AW];
endmodule

// File: rtl/busdp_checker.sv
module busdp_checker
   import busdp_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input logic             clk,
   input logic             clr,
   input logic [CW-1:0]    ctrl,
   input logic [DW-1:0]    bus,
   input logic [DW-1:0]    acc,
   input logic [DW-1:0]    outp,
   input logic [DW-AW-1:0] opcode,
   input logic [AW-1:0]    pc,
   input logic [AW-1:0]    mar
);
   ctrl_t c;
   assign c = ctrl_t'(ctrl);

   logic any_src;
   assign any_src = c.pc_oe | !c.ram_oe_n | !c.ir_oe_n | c.acc_oe | c.alu_oe;

   // R1
   a_r1_clear: assert property (@(posedge clk)
      clr |=> (pc == '0 && opcode == '0 && acc == '0 && outp == '0));

   // R2
   a_r2_single_source: assert property (@(posedge clk) disable iff (clr)
      $countones({c.pc_oe, !c.ram_oe_n, !c.ir_oe_n, c.acc_oe, c.alu_oe}) <= 1);

   a_r2_idle_zero: assert property (@(posedge clk) disable iff (clr)
      !any_src |-> bus == '0);

   // R3
   a_r3_mar_load: assert property (@(posedge clk) disable iff (clr)
      !c.mar_ld_n |=> mar == $past(bus[AW-1:0]));

   // R4
   a_r4_pc_inc: assert property (@(posedge clk) disable iff (clr)
      c.pc_inc |=> pc == $past(pc) + AW'(1));

   // R6
   a_r6_ir_load: assert property (@(posedge clk) disable iff (clr)
      !c.ir_ld_n |=> opcode == $past(bus[DW-1:AW]));

   // R7
   a_r7_acc_load: assert property (@(posedge clk) disable iff (clr)
      !c.acc_ld_n |=> acc == $past(bus));

   // R9
   a_r9_out_load: assert property (@(posedge clk) disable iff (clr)
      !c.out_ld_n |=> outp == $past(bus));

   // R10
   a_r10_acc_hold: assert property (@(posedge clk) disable iff (clr)
      c.acc_ld_n |=> $stable(acc));

   a_r10_out_hold: assert property (@(posedge clk) disable iff (clr)
      c.out_ld_n |=> $stable(outp));
endmodule

bind tiny_bus_datapath busdp_checker #(.DW(DW), .AW(AW)) u_chk (
   .clk(clk), .clr(clr), .ctrl(ctrl), .bus(bus_q), .acc(acc_q),
   .outp(out_q), .opcode(opcode), .pc(pc_q), .mar(mar_q)
);

// File: tb/sim_tiny_bus_datapath.sv
`timescale 1ns/100ps
module sim_tiny_bus_datapath;
   localparam int DW = 8;
   localparam int AW = 4;

   // control bit masks (bit 11 down to bit 0)
   localparam logic [11:0] M_INC  = 12'h800, M_PCOE = 12'h400, M_MARN = 12'h200,
                           M_RAMN = 12'h100, M_IRLN = 12'h080, M_IREN = 12'h040,
                           M_ACLN = 12'h020, M_ACOE = 12'h010, M_SUB  = 12'h008,
                           M_ALOE = 12'h004, M_BLN  = 12'h002, M_OLN  = 12'h001;
   localparam logic [11:0] W_IDLE = M_MARN | M_RAMN | M_IRLN | M_IREN | M_ACLN | M_BLN | M_OLN;
   localparam logic [11:0] W_T1   = (W_IDLE & ~M_MARN) | M_PCOE;
   localparam logic [11:0] W_T2   = W_IDLE | M_INC;
   localparam logic [11:0] W_T3   = W_IDLE & ~M_RAMN & ~M_IRLN;
   localparam logic [11:0] W_ADRM = W_IDLE & ~M_IREN & ~M_MARN;
   localparam logic [11:0] W_LDA5 = W_IDLE & ~M_RAMN & ~M_ACLN;
   localparam logic [11:0] W_LDB5 = W_IDLE & ~M_RAMN & ~M_BLN;
   localparam logic [11:0] W_ADD6 = (W_IDLE & ~M_ACLN) | M_ALOE;
   localparam logic [11:0] W_SUB6 = (W_IDLE & ~M_ACLN) | M_ALOE | M_SUB;
   localparam logic [11:0] W_OUT4 = (W_IDLE & ~M_OLN) | M_ACOE;
   localparam logic [11:0] W_A2M  = (W_IDLE & ~M_MARN) | M_ACOE;
   localparam logic [11:0] W_RDM  = W_IDLE & ~M_RAMN;

   localparam int K_ACC = 0, K_OUT = 1, K_BUS = 2, K_OP = 3;

   logic          clk = 1'b0;
   logic          clr = 1'b1;
   logic [11:0]   ctrl = W_IDLE;
   logic          prog_we = 1'b0;
   logic [AW-1:0] prog_addr = '0;
   logic [DW-1:0] prog_data = '0;
   logic [DW-AW-1:0] opcode;
   logic [DW-1:0] acc_q, out_q, bus_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int          kq[$];
   logic [7:0]  vq[$];
   string       rq[$];

   always #2.5 clk = ~clk;

   tiny_bus_datapath #(.DW(DW), .AW(AW)) u0 (
      .clk(clk), .clr(clr), .ctrl(ctrl), .prog_we(prog_we),
      .prog_addr(prog_addr), .prog_data(prog_data), .opcode(opcode),
      .acc_q(acc_q), .out_q(out_q), .bus_q(bus_q)
   );

   // driver side
   task automatic run(input logic [11:0] w);
      @(posedge clk); #1;
      ctrl = w;
   endtask

   task automatic expect_item(input int k, input logic [7:0] v, input string r);
      kq.push_back(k); vq.push_back(v); rq.push_back(r);
   endtask

   task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(posedge clk); #1;
      prog_we = 1'b1; prog_addr = a; prog_data = d;
   endtask

   // monitor: compare mid-cycle, away from the driving edge
   initial begin
      forever begin
         @(negedge clk);
         while (kq.size() > 0) begin
            int k;
            logic [7:0] e, act;
            string r;
            k = kq.pop_front(); e = vq.pop_front(); r = rq.pop_front();
            case (k)
               K_ACC:   act = acc_q;
               K_OUT:   act = out_q;
               K_BUS:   act = bus_q;
               default: act = {4'h0, opcode};
            endcase
            checks++;
            if (act !== e) begin
               errors++;
               $display("FAIL %s kind=%0d actual=%02h expected=%02h", r, k, act, e);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog all requirements actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // preload program while clear is held
      put(4'h0, 8'h09);   // load from 9
      put(4'h1, 8'h1A);   // add from A
      put(4'h2, 8'h2B);   // subtract from B
      put(4'h3, 8'hE0);   // output
      put(4'h9, 8'hAF);
      put(4'hA, 8'h70);
      put(4'hB, 8'h30);
      put(4'hF, 8'h5C);
      @(posedge clk); #1;
      prog_we = 1'b0; clr = 1'b0;

      run(W_IDLE);
      expect_item(K_ACC, 8'h00, "R1 reset acc");
      expect_item(K_OUT, 8'h00, "R1 reset out");
      expect_item(K_OP,  8'h00, "R1 reset opcode");
      expect_item(K_BUS, 8'h00, "R2 idle bus");

      // load instruction
      run(W_T1);   expect_item(K_BUS, 8'h00, "R3 pc on bus");
      run(W_T2);   expect_item(K_BUS, 8'h00, "R2 idle bus");
      run(W_T3);   expect_item(K_BUS, 8'h09, "R5 ram on bus");
      run(W_ADRM); expect_item(K_OP,  8'h00, "R6 opcode load");
                   expect_item(K_BUS, 8'h09, "R6 operand on bus");
      run(W_LDA5); expect_item(K_BUS, 8'hAF, "R5 data word");
      run(W_IDLE); expect_item(K_ACC, 8'hAF, "R7 acc load");

      // add instruction
      run(W_T1);   expect_item(K_BUS, 8'h01, "R4 pc increment");
      run(W_T2);
      run(W_T3);   expect_item(K_BUS, 8'h1A, "R5 ram on bus");
      run(W_ADRM); expect_item(K_OP,  8'h01, "R6 opcode load");
                   expect_item(K_BUS, 8'h0A, "R6 upper bits zero");
      run(W_LDB5); expect_item(K_BUS, 8'h70, "R5 data word");
      run(W_ADD6); expect_item(K_BUS, 8'h1F, "R8 add wraps");
      run(W_IDLE); expect_item(K_ACC, 8'h1F, "R7 acc from adder");

      // subtract instruction
      run(W_T1);   expect_item(K_BUS, 8'h02, "R4 pc increment");
      run(W_T2);
      run(W_T3);   expect_item(K_BUS, 8'h2B, "R5 ram on bus");
      run(W_ADRM); expect_item(K_OP,  8'h02, "R6 opcode load");
      run(W_LDB5); expect_item(K_BUS, 8'h30, "R9 operand value");
      run(W_SUB6); expect_item(K_BUS, 8'hEF, "R8 subtract borrows");
      run(W_IDLE); expect_item(K_ACC, 8'hEF, "R7 acc from subtract");

      // output instruction
      run(W_T1);   expect_item(K_BUS, 8'h03, "R4 pc increment");
                   expect_item(K_ACC, 8'hEF, "R10 acc holds");
      run(W_T2);   expect_item(K_OUT, 8'h00, "R10 out holds");
      run(W_T3);   expect_item(K_BUS, 8'hE0, "R5 ram on bus");
      run(W_OUT4); expect_item(K_OP,  8'h0E, "R6 opcode load");
                   expect_item(K_BUS, 8'hEF, "R7 acc on bus");
      run(W_IDLE); expect_item(K_OUT, 8'hEF, "R9 out load");
                   expect_item(K_BUS, 8'h00, "R2 idle bus with loaded acc");
      run(W_IDLE); expect_item(K_OUT, 8'hEF, "R10 idle keeps out");
                   expect_item(K_ACC, 8'hEF, "R10 idle keeps acc");
                   expect_item(K_OP,  8'h0E, "R10 idle keeps opcode");

      // address register takes only the low bits of the bus
      run(W_A2M);
      run(W_RDM);  expect_item(K_BUS, 8'h5C, "R3 mar low nibble");

      // mid-run clear
      @(posedge clk); #1;
      ctrl = W_IDLE; clr = 1'b1;
      @(posedge clk); #1;
      clr = 1'b0;
      expect_item(K_ACC, 8'h00, "R1 clear acc");
      expect_item(K_OUT, 8'h00, "R1 clear out");
      expect_item(K_OP,  8'h00, "R1 clear opcode");
      run(W_T1);   expect_item(K_BUS, 8'h00, "R1 clear pc");

      @(posedge clk); #1;
      ctrl = W_IDLE;
      @(negedge clk); #1;
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule